// File: doc/BRIEF.md
# Half-Duplex Asynchronous Serial Engine

This block sends or receives one asynchronous serial character at a time over a single transmit pin and a single receive pin. Both directions share one bit-timing counter, so the engine is always either idle, transmitting or receiving, and never does two of these at once. A host loads a byte and raises a put request to transmit. It raises a get request to arm the receiver. It then polls an 8-bit status word and, once the receive-busy bit drops, reads the received byte.

The bit rate comes from an external oversampling strobe (`tick`); one bit lasts `OVS` strobes. Character length (1 to 8 bits), parity on or off and parity sense are configuration inputs. They are captured when a request is accepted. Framing is one start bit (low), the data bits least-significant first, an optional parity bit and one stop bit (high). The line idles high.

The receiver waits for a falling edge and re-checks the line at mid start bit, rejecting glitches. It decides each later bit from two samples around mid-bit, with a third sample when those two disagree. It flags a low stop bit and a parity mismatch.

Top module: `hd_uart`

## Requirements
- R1: After reset the status word is 0x00, `txd` is 1 and `rx_data` is 0x00. Status bit 6 always reads 0. The layout is: bit0 transmit busy, bit1 transmit enable, bit2 receive active, bit3 receive busy, bit4 parity error, bit5 framing error, bit7 ninth (parity) bit.
- R2: A put or get request is taken only while status bits 0 and 3 are both 0; otherwise it has no effect. When both are raised together, put wins.
- R3: An accepted put sets bit1. Writing 0 to bit1 (`en_wr`=1, `en_wdata`=0) during a transmission stops it, so that on the next clock bit0 and bit1 are 0 and `txd` is 1.
- R4: A transmitted character is one low start bit, `len` data bits least-significant first, a parity bit if enabled and one high stop bit, each lasting `OVS` ticks. Bit0 stays 1 until the stop bit is complete: with `tick` high every clock, that is 8*(2+len+p) clocks for OVS=8, where p is 1 with parity and 0 without.
- R5: The parity bit makes the count of ones over the data bits and the parity bit even when `cfg_par_odd`=0, and odd when it is 1. After a put with parity on, bit7 holds the parity bit sent.
- R6: An accepted get sets bit3. A low pulse on `rxd` that ends before mid start bit is ignored: bit2 stays 0, bit3 stays 1, and a following valid character is received normally.
- R7: Each received bit is decided by majority, so a disturbance of one clock on `rxd` anywhere within a data bit does not change the received data.
- R8: A stop bit sampled low sets bit5. The data byte is still delivered.
- R9: When parity is on, bit4 is set if the received parity bit does not match the parity computed from the received data in the selected sense. Bit7 holds the received parity bit.
- R10: At the end of a character, bits 2 and 3 clear and `rx_data` holds the data right-aligned with the unused upper bits 0 (for 7-bit data, bit 7 is 0).
- R11: With parity off, bits 4 and 7 stay 0 after a reception.
- R12: An accepted get clears bits 4, 5 and 7 on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling strobe, OVS strobes per bit |
| cfg_len | input | 4 | Data bits per character, 1 to 8 (0 acts as 1, above 8 as 8) |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| tx_data | input | 8 | Byte to transmit, captured on an accepted put |
| put_req | input | 1 | Request to transmit `tx_data` |
| get_req | input | 1 | Request to arm the receiver |
| en_wr | input | 1 | Write strobe for the transmit-enable bit |
| en_wdata | input | 1 | Value written to the transmit-enable bit |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| status | output | 8 | Status and control word |
| rx_data | output | 8 | Last received character, right-aligned |

## Verification
The hardest cases to reach are those that depend on where a disturbance on `rxd` lands relative to the receiver's internal sample points. That position is hidden behind a two-stage synchronizer and the start-edge detector. The stimulus drives every receive frame on a fixed clock grid that starts with the start edge. It injects one-clock inversions at the grid offsets that fall on the first and on the second majority sample, and a low pulse that ends before the mid-start check. The other paths to reach are an abort in the middle of a character and a request made while the opposite direction is busy. Both are driven from the bench's own timeline, and the effect is read back through the status word and the line.

// File: rtl/hd_uart_pkg.sv
package hd_uart_pkg;

    localparam int DW = 8;
    localparam int LW = $clog2(DW + 1);

    localparam int ST_TXP   = 0;
    localparam int ST_TXEN  = 1;
    localparam int ST_RXACT = 2;
    localparam int ST_RXBSY = 3;
    localparam int ST_PERR  = 4;
    localparam int ST_FERR  = 5;
    localparam int ST_NINTH = 7;

    typedef struct packed {
        logic [LW-1:0] len;
        logic          par_en;
        logic          par_odd;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_WAIT, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    function automatic logic [LW-1:0] clamp_len(input logic [LW-1:0] l);
        if (l == '0) return LW'(1);
        if (int'(l) > DW) return LW'(DW);
        return l;
    endfunction

    function automatic logic [DW-1:0] len_mask(input logic [LW-1:0] l);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < DW; i++) begin
            if (i < int'(l)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic par_of(input logic [DW-1:0] d, input logic [LW-1:0] l,
                                    input logic odd);
        return (^(d & len_mask(l))) ^ odd;
    endfunction

endpackage

// File: rtl/hd_uart_tx.sv
module hd_uart_tx
    import hd_uart_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          start,
    input  logic          abort,
    input  frame_cfg_t    cfg,
    input  logic [DW-1:0] data,
    output logic          txd,
    output logic          busy,
    output logic          par_bit
);
    localparam int CW = $clog2(OVS);

    tx_state_e     st;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;
    logic [LW-1:0] left;
    logic          pen;
    logic          pbit;
    logic          last;

    assign last    = tick && (cnt == CW'(OVS - 1));
    assign busy    = (st != TX_IDLE);
    assign par_bit = pbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TX_IDLE;
            cnt  <= '0;
            sh   <= '0;
            left <= '0;
            pen  <= 1'b0;
            pbit <= 1'b0;
        end else if (start) begin
            st   <= TX_START;
            cnt  <= '0;
            sh   <= data & len_mask(clamp_len(cfg.len));
            left <= clamp_len(cfg.len);
            pen  <= cfg.par_en;
            pbit <= cfg.par_en & par_of(data, clamp_len(cfg.len), cfg.par_odd);
        end else if (abort) begin
            st  <= TX_IDLE;
            cnt <= '0;
        end else if (st != TX_IDLE && tick) begin
            cnt <= last ? '0 : cnt + 1'b1;
            if (last) begin
                unique case (st)
                    TX_START: st <= TX_DATA;
                    TX_DATA: begin
                        sh   <= sh >> 1;
                        left <= left - 1'b1;
                        if (left == LW'(1)) st <= pen ? TX_PAR : TX_STOP;
                    end
                    TX_PAR:  st <= TX_STOP;
                    TX_STOP: st <= TX_IDLE;
                    default: st <= TX_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            TX_PAR:   txd = pbit;
            default:  txd = 1'b1;
        endcase
    end

    // R4: every character begins with a low start bit
    a_r4_start_low: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    // R3: an abort returns the line to idle on the next clock
    a_r3_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (abort && !start) |=> (!busy && txd));

endmodule

// File: rtl/hd_uart_rx.sv
module hd_uart_rx
    import hd_uart_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          arm,
    input  frame_cfg_t    cfg,
    input  logic          rxd,
    output logic          busy,
    output logic          active,
    output logic [DW-1:0] data_o,
    output logic          perr,
    output logic          ferr,
    output logic          pbit
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;

    rx_state_e     st;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;
    logic [LW-1:0] left;
    logic [LW-1:0] len_l;
    logic          pen;
    logic          podd;
    logic          pr;
    logic          smp_a;
    logic          smp_b;
    logic          s1;
    logic          s2;
    logic          s2d;
    logic          done;
    logic          fall;
    logic          at_a;
    logic          at_b;
    logic          at_c;
    logic          last;
    logic          bitv;
    logic [DW-1:0] aligned;

    assign fall    = s2d & ~s2;
    assign at_a    = tick && (cnt == CW'(MID - 1));
    assign at_b    = tick && (cnt == CW'(MID));
    assign at_c    = tick && (cnt == CW'(MID + 1));
    assign last    = tick && (cnt == CW'(OVS - 1));
    assign bitv    = (smp_a == smp_b) ? smp_a : s2;
    assign aligned = sh >> (LW'(DW) - len_l);
    assign busy    = (st != RX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= 1'b1;
            s2  <= 1'b1;
            s2d <= 1'b1;
        end else begin
            s1  <= rxd;
            s2  <= s1;
            s2d <= s2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RX_IDLE;
            cnt    <= '0;
            sh     <= '0;
            left   <= '0;
            len_l  <= LW'(1);
            pen    <= 1'b0;
            podd   <= 1'b0;
            pr     <= 1'b0;
            smp_a  <= 1'b1;
            smp_b  <= 1'b1;
            active <= 1'b0;
            data_o <= '0;
            perr   <= 1'b0;
            ferr   <= 1'b0;
            pbit   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (arm) begin
                st     <= RX_WAIT;
                cnt    <= '0;
                sh     <= '0;
                pr     <= 1'b0;
                active <= 1'b0;
                len_l  <= clamp_len(cfg.len);
                pen    <= cfg.par_en;
                podd   <= cfg.par_odd;
                perr   <= 1'b0;
                ferr   <= 1'b0;
                pbit   <= 1'b0;
            end else begin
                unique case (st)
                    RX_IDLE: begin
                    end
                    RX_WAIT: begin
                        if (fall) begin
                            st  <= RX_START;
                            cnt <= '0;
                        end
                    end
                    default: begin
                        if (tick) begin
                            cnt <= last ? '0 : cnt + 1'b1;
                            if (at_a) smp_a <= s2;
                            if (at_b) smp_b <= s2;
                            if (st == RX_START) begin
                                if (at_b) begin
                                    if (s2) begin
                                        st  <= RX_WAIT;
                                        cnt <= '0;
                                    end else begin
                                        active <= 1'b1;
                                    end
                                end else if (last) begin
                                    st   <= RX_DATA;
                                    left <= len_l;
                                end
                            end else if (st == RX_DATA) begin
                                if (at_c) begin
                                    sh   <= {bitv, sh[DW-1:1]};
                                    left <= left - 1'b1;
                                end
                                if (last && left == '0) st <= pen ? RX_PAR : RX_STOP;
                            end else if (st == RX_PAR) begin
                                if (at_c) pr <= bitv;
                                if (last) st <= RX_STOP;
                            end else begin
                                if (at_c) begin
                                    st     <= RX_IDLE;
                                    cnt    <= '0;
                                    active <= 1'b0;
                                    done   <= 1'b1;
                                    data_o <= aligned;
                                    ferr   <= ~bitv;
                                    perr   <= pen & (pr != par_of(aligned, len_l, podd));
                                    pbit   <= pen & pr;
                                end
                            end
                        end
                    end
                endcase
            end
        end
    end

    // R10: a finished character leaves the receiver idle
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !active));

    // R11: no parity flags when parity is off
    a_r11_no_par_flags: assert property (@(posedge clk) disable iff (rst)
        (done && !pen) |-> (!perr && !pbit));

    // R12: arming clears all error flags
    a_r12_arm_clears: assert property (@(posedge clk) disable iff (rst)
        (arm && !busy) |=> (!perr && !ferr && !pbit));

    // R6: receive-active never appears without receive-busy
    a_r6_active_in_busy: assert property (@(posedge clk) disable iff (rst)
        active |-> busy);

endmodule

// File: rtl/hd_uart_stat.sv
module hd_uart_stat
    import hd_uart_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         put_req,
    input  logic         get_req,
    input  logic         en_wr,
    input  logic         en_wdata,
    input  logic         tx_busy,
    input  logic         tx_pbit,
    input  logic         rx_busy,
    input  logic         rx_active,
    input  logic         rx_perr,
    input  logic         rx_ferr,
    input  logic         rx_pbit,
    output logic         put_ok,
    output logic         get_ok,
    output logic         abort,
    output logic [7:0]   status
);
    logic free;
    logic en;
    logic dir_rx;

    assign free   = ~tx_busy & ~rx_busy;
    assign put_ok = put_req & free;
    assign get_ok = get_req & ~put_req & free;
    assign abort  = en_wr & ~en_wdata & ~put_ok & tx_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            dir_rx <= 1'b0;
        end else begin
            if (put_ok) en <= 1'b1;
            else if (en_wr) en <= en_wdata;
            if (put_ok) dir_rx <= 1'b0;
            else if (get_ok) dir_rx <= 1'b1;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_TXP]   = tx_busy;
        status[ST_TXEN]  = en;
        status[ST_RXACT] = rx_active;
        status[ST_RXBSY] = rx_busy;
        status[ST_PERR]  = rx_perr;
        status[ST_FERR]  = rx_ferr;
        status[ST_NINTH] = dir_rx ? rx_pbit : tx_pbit;
    end

    // R2: the two directions never run together
    a_r2_half_duplex: assert property (@(posedge clk) disable iff (rst)
        !(tx_busy && rx_busy));

    // R2: a get raised during a transmission is dropped
    a_r2_get_blocked: assert property (@(posedge clk) disable iff (rst)
        (get_req && tx_busy) |=> !rx_busy);

    // R3: an accepted put leaves the enable bit set
    a_r3_put_enables: assert property (@(posedge clk) disable iff (rst)
        put_ok |=> status[ST_TXEN]);

endmodule

// File: rtl/hd_uart.sv
module hd_uart
    import hd_uart_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [LW-1:0] cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic [DW-1:0] tx_data,
    input  logic          put_req,
    input  logic          get_req,
    input  logic          en_wr,
    input  logic          en_wdata,
    input  logic          rxd,
    output logic          txd,
    output logic [7:0]    status,
    output logic [DW-1:0] rx_data
);
    frame_cfg_t cfg;
    logic put_ok, get_ok, abort;
    logic tx_busy, tx_pbit;
    logic rx_busy, rx_active, rx_perr, rx_ferr, rx_pbit;

    assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd};

    hd_uart_stat u_stat (
        .clk(clk), .rst(rst), .put_req(put_req), .get_req(get_req),
        .en_wr(en_wr), .en_wdata(en_wdata), .tx_busy(tx_busy), .tx_pbit(tx_pbit),
        .rx_busy(rx_busy), .rx_active(rx_active), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_pbit(rx_pbit), .put_ok(put_ok), .get_ok(get_ok),
        .abort(abort), .status(status)
    );

    hd_uart_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .tick(tick), .start(put_ok), .abort(abort),
        .cfg(cfg), .data(tx_data), .txd(txd), .busy(tx_busy), .par_bit(tx_pbit)
    );

    hd_uart_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .arm(get_ok), .cfg(cfg), .rxd(rxd),
        .busy(rx_busy), .active(rx_active), .data_o(rx_data), .perr(rx_perr),
        .ferr(rx_ferr), .pbit(rx_pbit)
    );

endmodule

// File: tb/hd_uart_tb.sv
`timescale 1ns/1ps
module hd_uart_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic [3:0] cfg_len = 4'd8;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       put_req = 1'b0;
    logic       get_req = 1'b0;
    logic       en_wr = 1'b0;
    logic       en_wdata = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    logic [7:0] status;
    logic [7:0] rx_data;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    hd_uart u_dut (
        .clk(clk), .rst(rst), .tick(tick), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .tx_data(tx_data), .put_req(put_req), .get_req(get_req),
        .en_wr(en_wr), .en_wdata(en_wdata), .rxd(rxd), .txd(txd), .status(status),
        .rx_data(rx_data)
    );

    // len(4) par_en(1) par_odd(1) data(8) expected parity(1) expected busy clocks(9)
    localparam int NV = 8;
    localparam logic [23:0] VEC [NV] = '{
        {4'd8, 1'b0, 1'b0, 8'hA5, 1'b0, 9'd80},
        {4'd8, 1'b1, 1'b0, 8'hA5, 1'b0, 9'd88},
        {4'd8, 1'b1, 1'b1, 8'hA5, 1'b1, 9'd88},
        {4'd7, 1'b1, 1'b0, 8'h53, 1'b0, 9'd80},
        {4'd7, 1'b0, 1'b0, 8'hFF, 1'b0, 9'd72},
        {4'd1, 1'b1, 1'b1, 8'h01, 1'b0, 9'd32},
        {4'd5, 1'b1, 1'b0, 8'h1C, 1'b1, 9'd64},
        {4'd8, 1'b1, 1'b1, 8'h00, 1'b1, 9'd88}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_get();
        @(negedge clk); get_req = 1'b1;
        @(negedge clk); get_req = 1'b0;
    endtask

    task automatic drive_frame(input int len, input bit pen, input bit pb,
                               input logic [7:0] d, input bit stopv, input int goff);
        int nslots;
        nslots = 2 + len + (pen ? 1 : 0);
        for (int j = 0; j < nslots; j++) begin
            bit b;
            if (j == 0) b = 1'b0;
            else if (j <= len) b = d[j-1];
            else if (pen && j == len + 1) b = pb;
            else b = stopv;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                rxd = (goff >= 0 && c == goff && j >= 1 && j <= len) ? ~b : b;
            end
        end
        @(negedge clk); rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_tx(input int len, input bit pen, input bit podd, input logic [7:0] d,
                          input bit ep, input int ecyc);
        int c;
        logic [15:0] line;
        logic [15:0] expl;
        cfg_len = 4'(len); cfg_par_en = pen; cfg_par_odd = podd; tx_data = d;
        @(negedge clk); put_req = 1'b1;
        @(negedge clk); put_req = 1'b0;
        chk("R3", 32'(status[1]), 32'd1, "enable set by put");
        c = 0;
        line = '1;
        while (status[0] && c < 400) begin
            if (c % 8 == 4) line[c/8] = txd;
            c++;
            @(negedge clk);
        end
        chk("R4", 32'(c), 32'(ecyc), "busy clocks");
        expl = '1;
        expl[0] = 1'b0;
        for (int k = 1; k <= len; k++) expl[k] = d[k-1];
        if (pen) expl[len+1] = ep;
        chk("R4", 32'(line), 32'(expl), "line bits");
        chk("R5", 32'(status[7]), 32'(pen ? ep : 1'b0), "sent ninth bit");
    endtask

    task automatic run_rx(input int len, input bit pen, input bit podd, input logic [7:0] d,
                          input bit ep);
        cfg_len = 4'(len); cfg_par_en = pen; cfg_par_odd = podd;
        pulse_get();
        chk("R6", 32'(status[3]), 32'd1, "busy after get");
        drive_frame(len, pen, ep, d, 1'b1, -1);
        chk("R10", 32'(rx_data), 32'(d & (8'hFF >> (8 - len))), "received data");
        chk("R10", 32'(status[3:2]), 32'd0, "receive bits cleared");
        chk("R9", 32'(status[5:4]), 32'd0, "no errors");
        chk("R11", 32'(status[7]), 32'(pen ? ep : 1'b0), "received ninth bit");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", 32'(status), 32'h00, "reset status");
        chk("R1", 32'(txd), 32'd1, "reset line");
        chk("R1", 32'(rx_data), 32'h00, "reset data");

        for (int v = 0; v < NV; v++) begin
            logic [23:0] e;
            e = VEC[v];
            run_tx(int'(e[23:20]), e[19], e[18], e[17:10], e[9], int'(e[8:0]));
            run_rx(int'(e[23:20]), e[19], e[18], e[17:10], e[9]);
        end

        // R3 abort in the middle of a character
        cfg_len = 4'd8; cfg_par_en = 1'b0; tx_data = 8'h00;
        @(negedge clk); put_req = 1'b1;
        @(negedge clk); put_req = 1'b0;
        repeat (20) @(negedge clk);
        chk("R3", 32'(txd), 32'd0, "line low before abort");
        en_wr = 1'b1; en_wdata = 1'b0;
        @(negedge clk); en_wr = 1'b0;
        chk("R3", 32'(status[1:0]), 32'd0, "abort clears busy and enable");
        chk("R3", 32'(txd), 32'd1, "line idle after abort");

        // R2 get during a transmission is ignored
        @(negedge clk); put_req = 1'b1;
        @(negedge clk); put_req = 1'b0;
        repeat (5) @(negedge clk);
        pulse_get();
        repeat (2) @(negedge clk);
        chk("R2", 32'(status[3]), 32'd0, "get ignored while sending");
        for (int w = 0; w < 200 && status[0]; w++) @(negedge clk);

        // R6 start glitch, then R2 put while armed
        cfg_len = 4'd8; cfg_par_en = 1'b0;
        pulse_get();
        for (int c = 0; c < 3; c++) begin @(negedge clk); rxd = 1'b0; end
        @(negedge clk); rxd = 1'b1;
        repeat (12) @(negedge clk);
        chk("R6", 32'(status[3:2]), 32'b10, "glitch rejected, still armed");
        tx_data = 8'h00;
        @(negedge clk); put_req = 1'b1;
        @(negedge clk); put_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2", 32'(status[0]), 32'd0, "put ignored while armed");
        chk("R2", 32'(txd), 32'd1, "line untouched while armed");
        drive_frame(8, 1'b0, 1'b0, 8'h3C, 1'b1, -1);
        chk("R6", 32'(rx_data), 32'h3C, "frame after glitch");

        // R7 one-clock disturbances on the first and second samples
        pulse_get();
        drive_frame(8, 1'b0, 1'b0, 8'h96, 1'b1, 4);
        chk("R7", 32'(rx_data), 32'h96, "disturbance on first sample");
        pulse_get();
        drive_frame(8, 1'b0, 1'b0, 8'h69, 1'b1, 5);
        chk("R7", 32'(rx_data), 32'h69, "disturbance on second sample");

        // R8 low stop bit
        pulse_get();
        drive_frame(8, 1'b0, 1'b0, 8'h5A, 1'b0, -1);
        chk("R8", 32'(status[5]), 32'd1, "framing error");
        chk("R8", 32'(rx_data), 32'h5A, "data kept on framing error");

        // R9 wrong parity, even sense, 0xA5 needs 0
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        pulse_get();
        drive_frame(8, 1'b1, 1'b1, 8'hA5, 1'b1, -1);
        chk("R9", 32'(status[4]), 32'd1, "parity error");
        chk("R9", 32'(status[7]), 32'd1, "received ninth bit");
        chk("R8", 32'(status[5]), 32'd0, "no framing error");

        // R12 a new get clears error flags and the ninth bit
        pulse_get();
        chk("R12", 32'({status[7], status[5], status[4]}), 32'd0, "flags cleared by get");
        drive_frame(8, 1'b1, 1'b0, 8'hA5, 1'b0, -1);
        chk("R9", 32'(status[4]), 32'd0, "good parity after clear");
        chk("R1", 32'(status[6]), 32'd0, "bit 6 zero");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule